// File: doc/BRIEF.md
# EDO DRAM Controller with Refresh

This block sits between a host and an 8M x 8 asynchronous DRAM with extended-data-out page mode. The host offers a 23-bit byte address, a write flag and a write byte over a valid/ready handshake. Read data comes back with a one-cycle strobe. The controller divides the address into a row and a column and sends both over one shared address bus, row first. It drives the active-low row strobe, column strobe, write enable and output enable.

After an access the row stays open, so a later request to the same row needs only a column cycle. A request to another row precharges the open row before it opens the new one. A scheduler queues refreshes at a fixed interval. Each refresh runs with the column strobe falling before the row strobe. Pending refreshes may wait behind a burst of page hits, but only up to a set backlog. At that backlog the row is closed and the refreshes run.

A parameter selects the geometry: 12 row bits with 11 column bits, or 13 row bits with 10 column bits. Phase lengths are counted in controller clocks and set by parameters: RAS-to-CAS delay `T_RCD`, CAS width `T_CAS`, precharge `T_RP` and refresh RAS width `T_RFC`. The refresh period `REF_INTERVAL` and the backlog limit `MAX_DEFER` are parameters as well.

Top module: `edo_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: With `ROW13`=0 the row is `req_addr[22:11]` and the column is `req_addr[10:0]`. With `ROW13`=1 the row is `req_addr[22:10]` and the column is `req_addr[9:0]`. Both are zero-extended on the 13-bit `dram_addr`.
- R3: For a request accepted with no row open, the row is on `dram_addr` one cycle after the handshake edge. `dram_ras_n` falls on the next edge. `dram_cas_n` falls `T_RCD`+1 edges after that, with the column already on the bus the cycle before.
- R4: A read returns `dram_dq_in`, as sampled on the edge where CAS rises, on `rd_data` with `rd_valid` high for one cycle. That strobe comes 2+`T_RCD`+`T_CAS` edges after a closed-row handshake, or 1+`T_CAS` edges after a page-hit handshake.
- R5: During a write column cycle `dram_we_n` is low, `dram_dq_oe` is high, `dram_dq_out` carries the write byte and `dram_oe_n` stays high. A write produces no `rd_valid`.
- R6: A request to the open row is accepted while the row is open. `dram_ras_n` stays low, and `dram_cas_n` falls one edge after the handshake.
- R7: A request to another row is not accepted while a row is open. `dram_ras_n` goes high for at least `T_RP` cycles, and then the new row is opened as in R3.
- R8: A refresh drives `dram_cas_n` low while `dram_ras_n` is high. On the next edge `dram_ras_n` falls with `dram_cas_n` still low and `dram_we_n` high.
- R9: With no host traffic, successive refreshes start exactly `REF_INTERVAL` cycles apart.
- R10: A due refresh closes an idle open row, taking at least `T_RP` precharge cycles before the refresh. A request to that row afterwards takes the closed-row path.
- R11: While fewer than `MAX_DEFER` refreshes are pending, page hits continue to be served. When `MAX_DEFER` are pending, the row is closed and the whole backlog runs back to back.
- R12: `dram_oe_n` is low only while `dram_cas_n` is low during a read column cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Read byte |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from memory |

## Verification
Every result is due at a fixed edge count after the handshake edge. For a closed-row access, RAS falls 1 edge after it, CAS falls 2+`T_RCD` edges after it and read data appears 2+`T_RCD`+`T_CAS` edges after it. For a page hit, CAS falls 1 edge after the handshake and data appears 1+`T_CAS` edges after it. The bench drives and samples on falling clock edges. It counts falling edges from the handshake and checks each output on exactly the edge where it is due, including one edge early, where it must still be inactive. Refresh results have no request to count from, so the bench first waits for a refresh to start. It then checks the refresh spacing, the precharge run before the refresh, and the deferral window against the cycle counts those requirements give.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int ADDR_W = 23;
    localparam int DQ_W   = 8;
    localparam int BUS_W  = 13;
    localparam int CNT_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ROW, ST_RCD, ST_COLSET, ST_CAS,
        ST_OPEN, ST_PRE, ST_RCAS, ST_RRAS
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [BUS_W-1:0]  bus;
        logic [DQ_W-1:0]   dq_out;
        logic              rd_valid;
        logic [DQ_W-1:0]   rd_data;
        logic              row_open;
        logic [BUS_W-1:0]  open_row;
        logic [BUS_W-1:0]  col;
        logic              wr;
    } ctl_regs_t;
endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split
    import edo_pkg::*;
#(
    parameter bit ROW13 = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  row,
    output logic [BUS_W-1:0]  col
);
    localparam int ROW_W = ROW13 ? 13 : 12;
    localparam int COL_W = ADDR_W - ROW_W;

    generate
        if (ROW13) begin : g_tall
            assign row = addr[ADDR_W-1 -: ROW_W];
            assign col = {{(BUS_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end else begin : g_wide
            assign row = {{(BUS_W-ROW_W){1'b0}}, addr[ADDR_W-1 -: ROW_W]};
            assign col = {{(BUS_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/edo_ref_sched.sv
module edo_ref_sched #(
    parameter int REF_INTERVAL = 780,
    parameter int MAX_DEFER    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic ref_due,
    output logic ref_force
);
    localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam int PW = $clog2(MAX_DEFER + 1);
    localparam logic [TW-1:0] T_LAST = TW'(REF_INTERVAL - 1);
    localparam logic [PW-1:0] P_MAX  = PW'(MAX_DEFER);

    logic [TW-1:0] tick_cnt_d, tick_cnt_q;
    logic [PW-1:0] pend_d, pend_q;
    logic          tick;

    always_comb begin
        tick       = (tick_cnt_q == T_LAST);
        tick_cnt_d = tick ? '0 : tick_cnt_q + 1'b1;
        pend_d     = pend_q;
        // a tick at the cap is dropped; the backlog is already forcing service
        if (tick && (pend_q != P_MAX) && !ref_done) pend_d = pend_q + 1'b1;
        else if (ref_done && !(tick && (pend_q != P_MAX))) pend_d = pend_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
            pend_q     <= '0;
        end else begin
            tick_cnt_q <= tick_cnt_d;
            pend_q     <= pend_d;
        end
    end

    assign ref_due   = (pend_q != '0);
    assign ref_force = (pend_q == P_MAX);

    assert_pend_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= P_MAX);
    assert_done_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> (pend_q != '0));
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter bit ROW13        = 1'b0,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 2,
    parameter int T_RFC        = 4,
    parameter int REF_INTERVAL = 780,
    parameter int MAX_DEFER    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    localparam logic [CNT_W-1:0] C_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] C_CAS = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] C_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] C_RFC = CNT_W'(T_RFC - 1);

    ctl_regs_t        cur_q, nx_d;
    logic [BUS_W-1:0] req_row, req_col;
    logic             ref_due, ref_force, ref_done, rdy, page_hit;

    edo_addr_split #(.ROW13(ROW13)) u_split (
        .addr(req_addr), .row(req_row), .col(req_col)
    );

    edo_ref_sched #(.REF_INTERVAL(REF_INTERVAL), .MAX_DEFER(MAX_DEFER)) u_sched (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_done),
        .ref_due(ref_due), .ref_force(ref_force)
    );

    always_comb begin
        nx_d          = cur_q;
        nx_d.rd_valid = 1'b0;
        rdy           = 1'b0;
        ref_done      = 1'b0;
        page_hit      = cur_q.row_open && (req_row == cur_q.open_row);
        case (cur_q.state)
            ST_IDLE: begin
                if (ref_due) begin
                    nx_d.cas_n = 1'b0;
                    nx_d.state = ST_RCAS;
                end else begin
                    rdy = 1'b1;
                    if (req_valid) begin
                        nx_d.bus      = req_row;
                        nx_d.open_row = req_row;
                        nx_d.col      = req_col;
                        nx_d.wr       = req_write;
                        nx_d.dq_out   = req_wdata;
                        nx_d.state    = ST_ROW;
                    end
                end
            end
            ST_ROW: begin
                nx_d.ras_n    = 1'b0;
                nx_d.row_open = 1'b1;
                nx_d.cnt      = C_RCD;
                nx_d.state    = ST_RCD;
            end
            ST_RCD: begin
                if (cur_q.cnt != '0) nx_d.cnt = cur_q.cnt - 1'b1;
                else begin
                    nx_d.bus   = cur_q.col;
                    nx_d.we_n  = !cur_q.wr;
                    nx_d.dq_oe = cur_q.wr;
                    nx_d.state = ST_COLSET;
                end
            end
            ST_COLSET: begin
                nx_d.cas_n = 1'b0;
                nx_d.oe_n  = cur_q.wr;
                nx_d.cnt   = C_CAS;
                nx_d.state = ST_CAS;
            end
            ST_CAS: begin
                if (cur_q.cnt != '0) nx_d.cnt = cur_q.cnt - 1'b1;
                else begin
                    nx_d.cas_n    = 1'b1;
                    nx_d.oe_n     = 1'b1;
                    nx_d.we_n     = 1'b1;
                    nx_d.dq_oe    = 1'b0;
                    nx_d.rd_valid = !cur_q.wr;
                    if (!cur_q.wr) nx_d.rd_data = dram_dq_in;
                    nx_d.state    = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (req_valid && page_hit && !ref_force) begin
                    rdy         = 1'b1;
                    nx_d.bus    = req_col;
                    nx_d.wr     = req_write;
                    nx_d.we_n   = !req_write;
                    nx_d.dq_oe  = req_write;
                    nx_d.dq_out = req_wdata;
                    nx_d.state  = ST_COLSET;
                end else if (ref_due || req_valid) begin
                    nx_d.ras_n    = 1'b1;
                    nx_d.row_open = 1'b0;
                    nx_d.cnt      = C_RP;
                    nx_d.state    = ST_PRE;
                end
            end
            ST_PRE: begin
                if (cur_q.cnt != '0) nx_d.cnt = cur_q.cnt - 1'b1;
                else nx_d.state = ST_IDLE;
            end
            ST_RCAS: begin
                nx_d.ras_n = 1'b0;
                nx_d.cnt   = C_RFC;
                nx_d.state = ST_RRAS;
            end
            ST_RRAS: begin
                if (cur_q.cnt != '0) nx_d.cnt = cur_q.cnt - 1'b1;
                else begin
                    ref_done   = 1'b1;
                    nx_d.ras_n = 1'b1;
                    nx_d.cas_n = 1'b1;
                    nx_d.cnt   = C_RP;
                    nx_d.state = ST_PRE;
                end
            end
            default: nx_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
            cur_q.ras_n <= 1'b1;
            cur_q.cas_n <= 1'b1;
            cur_q.we_n  <= 1'b1;
            cur_q.oe_n  <= 1'b1;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign req_ready   = rdy;
    assign rd_valid    = cur_q.rd_valid;
    assign rd_data     = cur_q.rd_data;
    assign dram_addr   = cur_q.bus;
    assign dram_ras_n  = cur_q.ras_n;
    assign dram_cas_n  = cur_q.cas_n;
    assign dram_we_n   = cur_q.we_n;
    assign dram_oe_n   = cur_q.oe_n;
    assign dram_dq_out = cur_q.dq_out;
    assign dram_dq_oe  = cur_q.dq_oe;

    assert_col_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_addr));
    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n && !dram_ras_n));
    assert_cbr_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_ras_n) |=> (!dram_ras_n && !dram_cas_n && dram_we_n));
    assert_oe_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (!dram_cas_n && dram_we_n));
endmodule

// File: tb/tb_edo_ctrl.sv
module tb_edo_ctrl;
    localparam int RI = 400;
    localparam int MD = 2;
    localparam int TRCD = 2;
    localparam int TCAS = 2;
    localparam int TRP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, dq_in = '0;
    logic        req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [7:0]  rd_data, dq_out;
    logic [12:0] dram_addr;
    logic        r13_ready, r13_rdv, r13_ras, r13_cas, r13_we, r13_oe, r13_dqoe;
    logic [7:0]  r13_rdd, r13_dqo;
    logic [12:0] r13_addr;

    int checks = 0, fails = 0, wait_hi = 0;
    int unsigned cyc = 0;
    int cbr_n = 0;
    int unsigned cbr_t [0:7];
    logic cas_prev = 1'b1;

    always #10 clk = ~clk;

    edo_ctrl #(.ROW13(1'b0), .T_RCD(TRCD), .T_CAS(TCAS), .T_RP(TRP), .T_RFC(4),
               .REF_INTERVAL(RI), .MAX_DEFER(MD)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    edo_ctrl #(.ROW13(1'b1), .T_RCD(TRCD), .T_CAS(TCAS), .T_RP(TRP), .T_RFC(4),
               .REF_INTERVAL(RI), .MAX_DEFER(MD)) dut13 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r13_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(r13_rdv), .rd_data(r13_rdd), .dram_addr(r13_addr),
        .dram_ras_n(r13_ras), .dram_cas_n(r13_cas), .dram_we_n(r13_we), .dram_oe_n(r13_oe),
        .dram_dq_out(r13_dqo), .dram_dq_oe(r13_dqoe), .dram_dq_in(dq_in));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!cas_n && ras_n && cas_prev) begin
            cbr_t[cbr_n % 8] = cyc;
            cbr_n = cbr_n + 1;
        end
        cas_prev = cas_n;
    end

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [22:0] a, input logic w, input logic [7:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd;
        wait_hi = 0;
        while (!req_ready) begin
            @(negedge clk);
            if (ras_n) wait_hi++;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_cbr(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(!cas_n && ras_n));
    endtask

    task automatic sync_ref();
        int n;
        wait_cbr(n);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 strobes", ras_n && cas_n && we_n && oe_n, {ras_n, cas_n, we_n, oe_n}, 4'hF);
        chk("R1 dq_oe/rd_valid", !dq_oe && !rd_valid, {dq_oe, rd_valid}, 0);
        chk("R1 ready", req_ready, req_ready, 1);
    endtask

    task automatic t_interval();
        int c1, c2;
        wait_cbr(c1);
        @(negedge clk);
        chk("R8 cbr ras follows", !ras_n && !cas_n && we_n, {ras_n, cas_n, we_n}, 3'b001);
        wait_cbr(c2);
        chk("R9 interval", (c2 + 1) == RI, c2 + 1, RI);
    endtask

    task automatic t_access(input logic [22:0] a1);
        logic [22:0] a2, a3;
        a2 = {a1[22:10], 10'h0F1};
        a3 = a1 ^ 23'h400000;
        sync_ref();
        dq_in = 8'hA5;
        do_req(a1, 1'b0, 8'h00);
        chk("R2 row on bus", ras_n && dram_addr == {1'b0, a1[22:11]}, dram_addr, {1'b0, a1[22:11]});
        @(negedge clk);
        chk("R3 ras falls", !ras_n, ras_n, 0);
        chk("R2 row13 bus", r13_addr == a1[22:10], r13_addr, a1[22:10]);
        repeat (2) @(negedge clk);
        chk("R3 cas not early", cas_n, cas_n, 1);
        @(negedge clk);
        chk("R3 cas falls", !cas_n, cas_n, 0);
        chk("R2 col on bus", dram_addr == {2'b0, a1[10:0]}, dram_addr, {2'b0, a1[10:0]});
        chk("R2 col13 bus", r13_addr == {3'b0, a1[9:0]}, r13_addr, {3'b0, a1[9:0]});
        chk("R12 oe during read", !oe_n && we_n, {oe_n, we_n}, 2'b01);
        repeat (2) @(negedge clk);
        chk("R4 closed rd_valid", rd_valid && rd_data == 8'hA5, {rd_valid, rd_data}, 9'h1A5);
        chk("R12 oe released", oe_n, oe_n, 1);
        @(negedge clk);
        chk("R4 single pulse", !rd_valid, rd_valid, 0);
        // write hit
        do_req(a2, 1'b1, 8'h3C);
        chk("R6 hit col setup", !ras_n && cas_n && dram_addr == {2'b0, a2[10:0]}, dram_addr, {2'b0, a2[10:0]});
        @(negedge clk);
        chk("R6 hit cas falls", !cas_n && !ras_n, {ras_n, cas_n}, 0);
        chk("R5 write drive", !we_n && dq_oe && oe_n && dq_out == 8'h3C, {we_n, dq_oe, oe_n, dq_out}, 11'h33C);
        repeat (2) @(negedge clk);
        chk("R5 no read strobe", cas_n && !rd_valid, {cas_n, rd_valid}, 2'b10);
        // read hit
        dq_in = 8'h5A;
        do_req(a2, 1'b0, 8'h00);
        @(negedge clk);
        chk("R6 read hit cas", !cas_n && !ras_n && !oe_n, {ras_n, cas_n, oe_n}, 0);
        repeat (2) @(negedge clk);
        chk("R4 hit rd_valid", rd_valid && rd_data == 8'h5A && !ras_n, {rd_valid, rd_data}, 9'h15A);
        // miss
        @(negedge clk);
        req_valid = 1'b1; req_addr = a3; req_write = 1'b0;
        chk("R7 miss not accepted", !req_ready, req_ready, 0);
        req_valid = 1'b0;
        do_req(a3, 1'b0, 8'h00);
        chk("R7 precharge length", wait_hi >= TRP, wait_hi, TRP);
        chk("R7 ras high before open", ras_n, ras_n, 1);
        @(negedge clk);
        chk("R7 new row opened", !ras_n && dram_addr == {1'b0, a3[22:11]}, dram_addr, {1'b0, a3[22:11]});
        repeat (6) @(negedge clk);
    endtask

    task automatic t_ref_close(input logic [22:0] a);
        int hi;
        hi = 0;
        chk("R10 row open before", !ras_n, ras_n, 0);
        while (!(!cas_n && ras_n)) begin
            @(negedge clk);
            if (ras_n && cas_n) hi++; else if (!ras_n) hi = 0;
        end
        chk("R10 precharge before refresh", hi >= TRP, hi, TRP);
        repeat (10) @(negedge clk);
        do_req(a, 1'b0, 8'h00);
        chk("R10 row closed after refresh", ras_n, ras_n, 1);
        @(negedge clk);
        chk("R10 reopen", !ras_n, ras_n, 0);
    endtask

    task automatic t_defer(input logic [22:0] a);
        int unsigned t0, f1, f2;
        int n0;
        sync_ref();
        t0 = cyc;
        n0 = cbr_n;
        do_req(a, 1'b0, 8'h00);
        while (cyc < t0 + 2 * RI + 100) do_req({a[22:10], cyc[9:0]}, 1'b0, 8'h00);
        repeat (5) @(negedge clk);
        chk("R11 backlog count", (cbr_n - n0) == MD, cbr_n - n0, MD);
        f1 = cbr_t[n0 % 8];
        f2 = cbr_t[(n0 + 1) % 8];
        chk("R11 deferred past one interval", f1 > t0 + RI + 20, f1 - t0, RI + 20);
        chk("R11 forced close", f1 < t0 + 2 * RI + 60, f1 - t0, 2 * RI + 60);
        chk("R11 backlog back to back", (f2 - f1) <= 20, f2 - f1, 20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_interval();
        t_access(23'h51A3C5);
        t_ref_close(23'h11A3C5);
        t_defer(23'h2B0123);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule